// File: doc/BRIEF.md
# Pseudo-DMA Address Decode Glue

This block sits between a processor bus and a peripheral controller that offers two ways into its data FIFO: the normal chip-select register port, and a DMA acknowledge input that connects the FIFO to the data bus without looking at the address. The glue takes one I/O-range select and five address bits. A FIFO access at register offset 2 is steered onto the acknowledge line. Every other register offset is steered onto chip select. A software polling loop can then move bytes through the acknowledge path, which lets the processor stand in for a DMA engine.

Address bit A4 is never passed to the peripheral. Instead it opens a read-only status port that reports the peripheral's DMA request level on data bit 7. This bit can be tested with a single bit-test instruction. The status driver has its own output enable, which feeds an external tri-state buffer. The request level is held in a register so that it stays constant for the whole status read. All other outputs are combinational.

Top module: `pdma_glue`

## Requirements
- R1: With `range_sel`=1, `addr[4]`=0 and `addr[3:0]` not equal to 2, `cs_n` is 0 and `dack_n` is 1 in the same cycle. The strobes have no effect on this.
- R2: With `range_sel`=1, `addr[4]`=0 and `addr[3:0]`=2, `dack_n` is 0 and `cs_n` is 1. The strobes have no effect on this.
- R3: With `range_sel`=1 and `addr[4]`=1, `cs_n` and `dack_n` are both 1, whatever the value of `addr[3:0]`.
- R4: With `range_sel`=0, `cs_n`=1, `dack_n`=1, `stat_oe`=0 and `stat_data`=8'h00.
- R5: `stat_oe` is 1 exactly when `range_sel`=1, `addr[4]`=1 and `rd_en`=1. A write to the status port (`wr_en`=1, `rd_en`=0) leaves it at 0.
- R6: While `stat_oe`=1, `stat_data[7]` holds the DMA request level that was registered at the last rising clock edge before the read began. The register follows `dreq` at every edge on which no status read is active. It keeps its value during a read and resets to 0.
- R7: While `stat_oe`=1, `stat_data[6:0]` is 0. While `stat_oe`=0, the whole of `stat_data` is 0.
- R8: `stat_oe`=1 never coincides with `cs_n`=0 or `dack_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the request sample register |
| rst_n | input | 1 | Active-low reset, clears the request sample |
| range_sel | input | 1 | Peripheral I/O range selected (active high) |
| addr | input | 5 | Low address bits; bit 4 selects the status port |
| rd_en | input | 1 | Bus read strobe (active high) |
| wr_en | input | 1 | Bus write strobe (active high) |
| dreq | input | 1 | DMA request from the peripheral |
| cs_n | output | 1 | Peripheral chip select (active low) |
| dack_n | output | 1 | Peripheral DMA acknowledge (active low) |
| stat_data | output | 8 | Status byte, request level on bit 7 |
| stat_oe | output | 1 | Enable for the external status bus driver |

## Verification
The select lines, the acknowledge line, the status enable and the low status bits are all combinational. The bench therefore drives each vector on the falling clock edge and samples it 5 ns later, within that same half cycle. Status bit 7 reflects the request level registered one rising edge earlier. The bench's reference copy of that register updates on the same rising edge as the design's, so the value expected at each falling-edge sample already includes the most recent capture. Directed cases change `dreq` partway through a multi-cycle status read to confirm that the bit holds.

// File: rtl/pdma_glue_pkg.sv
package pdma_glue_pkg;
  localparam int ADDR_W   = 5;
  localparam int REG_W    = 4;
  localparam int DATA_W   = 8;
  localparam int FLAG_BIT = 7;
  localparam logic [REG_W-1:0] FIFO_REG = 4'd2;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_REG  = 2'd1,
    TGT_FIFO = 2'd2,
    TGT_STAT = 2'd3
  } tgt_e;

  function automatic tgt_e classify(input logic sel, input logic [ADDR_W-1:0] a);
    if (!sel)                             return TGT_NONE;
    else if (a[ADDR_W-1])                 return TGT_STAT;
    else if (a[REG_W-1:0] == FIFO_REG)    return TGT_FIFO;
    else                                  return TGT_REG;
  endfunction

  function automatic logic [DATA_W-1:0] status_byte(input logic flag);
    logic [DATA_W-1:0] b;
    b = '0;
    b[FLAG_BIT] = flag;
    return b;
  endfunction
endpackage

// File: rtl/pdma_addr_decode.sv
module pdma_addr_decode
  import pdma_glue_pkg::*;
(
  input  logic              range_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  output logic              fifo_hit,
  output logic              reg_hit,
  output logic              stat_rd
);
  tgt_e tgt;

  always_comb begin
    tgt      = classify(range_sel, addr);
    fifo_hit = (tgt == TGT_FIFO);
    reg_hit  = (tgt == TGT_REG);
    stat_rd  = (tgt == TGT_STAT) && rd_en;
  end
endmodule

// File: rtl/pdma_status_port.sv
module pdma_status_port
  import pdma_glue_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_rd,
  input  logic              dreq,
  output logic              dreq_held,
  output logic [DATA_W-1:0] stat_data,
  output logic              stat_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dreq_held <= 1'b0;
    else if (!stat_rd) dreq_held <= dreq;
  end

  always_comb begin
    stat_oe   = stat_rd;
    stat_data = stat_rd ? status_byte(dreq_held) : '0;
  end
endmodule

// File: rtl/pdma_glue.sv
module pdma_glue
  import pdma_glue_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        range_sel,
  input  logic [4:0]  addr,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic        dreq,
  output logic        cs_n,
  output logic        dack_n,
  output logic [7:0]  stat_data,
  output logic        stat_oe
);
  logic fifo_hit;
  logic reg_hit;
  logic stat_rd;
  logic dreq_held;
  logic wr_unused;

  assign wr_unused = wr_en;

  pdma_addr_decode u_dec (
    .range_sel (range_sel),
    .addr      (addr),
    .rd_en     (rd_en),
    .fifo_hit  (fifo_hit),
    .reg_hit   (reg_hit),
    .stat_rd   (stat_rd)
  );

  pdma_status_port u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_rd   (stat_rd),
    .dreq      (dreq),
    .dreq_held (dreq_held),
    .stat_data (stat_data),
    .stat_oe   (stat_oe)
  );

  assign cs_n   = ~reg_hit;
  assign dack_n = ~fifo_hit;
endmodule

// File: rtl/pdma_glue_checker.sv
module pdma_glue_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       range_sel,
  input logic [4:0] addr,
  input logic       rd_en,
  input logic       dreq,
  input logic       cs_n,
  input logic       dack_n,
  input logic [7:0] stat_data,
  input logic       stat_oe
);
  assert_reg_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (range_sel && !addr[4] && addr[3:0] != 4'd2) |-> (!cs_n && dack_n));

  assert_fifo_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (range_sel && !addr[4] && addr[3:0] == 4'd2) |-> (cs_n && !dack_n));

  assert_a4_isolates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (range_sel && addr[4]) |-> (cs_n && dack_n));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !range_sel |-> (cs_n && dack_n && !stat_oe));

  assert_oe_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (range_sel && addr[4] && rd_en) |-> stat_oe);

  assert_oe_only_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_oe |-> (range_sel && addr[4] && rd_en));

  assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_oe && $past(stat_oe)) |-> $stable(stat_data[7]));

  assert_low_bits_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_data[6:0] == 7'd0);

  assert_quiet_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_oe |-> (stat_data == 8'h00));

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_oe |-> (cs_n && dack_n));
endmodule

bind pdma_glue pdma_glue_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .range_sel (range_sel),
  .addr      (addr),
  .rd_en     (rd_en),
  .dreq      (dreq),
  .cs_n      (cs_n),
  .dack_n    (dack_n),
  .stat_data (stat_data),
  .stat_oe   (stat_oe)
);

// File: tb/pdma_glue_test.sv
`timescale 1ns/1ps
module pdma_glue_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       range_sel = 1'b0;
  logic [4:0] addr = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       dreq = 1'b0;
  logic       cs_n, dack_n, stat_oe;
  logic [7:0] stat_data;

  int vectors = 0;
  int errors  = 0;
  logic ref_flag = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pdma_glue uut (
    .clk(clk), .rst_n(rst_n), .range_sel(range_sel), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .dreq(dreq), .cs_n(cs_n),
    .dack_n(dack_n), .stat_data(stat_data), .stat_oe(stat_oe)
  );

  function automatic bit want_status_read(logic s, logic [4:0] a, logic r);
    return s & a[4] & r;
  endfunction
  function automatic logic want_cs_n(logic s, logic [4:0] a);
    return !(s && !a[4] && (a[3:0] != 4'd2));
  endfunction
  function automatic logic want_dack_n(logic s, logic [4:0] a);
    return !(s && !a[4] && (a[3:0] == 4'd2));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_flag <= 1'b0;
    else if (!want_status_read(range_sel, addr, rd_en)) ref_flag <= dreq;
  end

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (sel=%b addr=%h rd=%b wr=%b)",
               tag, got, exp, range_sel, addr, rd_en, wr_en);
    end
  endtask

  task automatic check_all();
    logic rdx;
    string t;
    rdx = want_status_read(range_sel, addr, rd_en);
    if (!range_sel) t = "R4";
    else if (addr[4]) t = "R3";
    else if (addr[3:0] == 4'd2) t = "R2";
    else t = "R1";
    check({t, " cs_n"},   {7'd0, cs_n},   {7'd0, want_cs_n(range_sel, addr)});
    check({t, " dack_n"}, {7'd0, dack_n}, {7'd0, want_dack_n(range_sel, addr)});
    check("R5 stat_oe",   {7'd0, stat_oe}, {7'd0, rdx});
    check("R6/R7 stat_data", stat_data, rdx ? {ref_flag, 7'd0} : 8'h00);
    if (stat_oe && (!cs_n || !dack_n)) check("R8 contention", 8'h01, 8'h00);
  endtask

  task automatic apply(logic s, logic [4:0] a, logic r, logic w, logic d);
    @(negedge clk);
    range_sel = s; addr = a; rd_en = r; wr_en = w; dreq = d;
    #5;
    check_all();
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // reset state, R4
    #5; check_all();
    repeat (3) @(negedge clk);
    #5; check_all();
    rst_n = 1'b1;
    // R1: register offsets, strobe independence
    apply(1, 5'h00, 1, 0, 0);
    apply(1, 5'h0F, 0, 1, 0);
    apply(1, 5'h03, 0, 0, 1);
    // R2: FIFO via acknowledge
    apply(1, 5'h02, 1, 0, 0);
    apply(1, 5'h02, 0, 1, 1);
    // R3 & R5: status write is ignored
    apply(1, 5'h10, 0, 1, 1);
    apply(1, 5'h12, 0, 0, 1);
    // R6: flag sampled before the read, held while dreq drops
    apply(1, 5'h10, 1, 0, 0);
    apply(1, 5'h10, 1, 0, 0);
    apply(1, 5'h17, 1, 0, 1);
    apply(1, 5'h00, 0, 0, 1);
    apply(1, 5'h10, 1, 0, 1);
    apply(0, 5'h10, 1, 0, 0);
    apply(0, 5'h02, 1, 1, 1);
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a;
      a = 5'($urandom);
      if ($urandom_range(0, 3) == 0) a = {a[4], 4'd2};
      apply(($urandom_range(0, 7) != 0), a, 1'($urandom), 1'($urandom),
            1'($urandom));
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule